// File: doc/BRIEF.md
# Cascaded Divide-by-2/3 Programmable Clock Divider

This block divides a fast clock by an integer ratio between 64 and 127. It is made of six identical stages, and each stage divides by two or by three. A modulus-control flag travels from the slowest stage back toward the fastest stage. Each stage adds one extra input cycle (it "swallows" a cycle) at most once per output period. It does so only when the flag from the stage behind it is high and its own program bit is set. Stage k sits at position k from the fast end and contributes 2^k input cycles when it swallows. The total ratio is therefore 64 plus the 6-bit program word.

All stages run from the single input clock. A stage advances only on cycles where the stage before it passes a carry along, so the chain behaves like the classic cascade of dual-modulus cells in a synchronous form. The fastest stage's modulus-out marks the last input cycle of each output period. A register turns that into a one-cycle output pulse. The program word is captured at the start of each output period, so a change applies only from the next period on.

Top module: `dual_mod_chain_div`

## Requirements
- R1: With program word P (bit 0 weight 1 up to bit 5 weight 32), consecutive output pulses are exactly 64 + P input clock cycles apart.
- R2: P = 0 gives a period of 64 cycles and P = 63 gives a period of 127 cycles.
- R3: The output is high for exactly one input clock cycle per output period and low in every other cycle.
- R4: The program word is sampled on the same clock edge on which the output pulse rises, and that value alone sets the length of the following period. Changes at any other time do not alter the period in progress.
- R5: While reset is high the output is low. After reset falls, the first pulse rises on the N-th rising edge, where N = 64 + P and P is the program word present at the last reset edge.
- R6: Asserting reset in the middle of a period discards the partial period, and the timing restarts exactly as in R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast input clock |
| rst_i | input | 1 | Synchronous active-high reset |
| ratio_i | input | 6 | Program word P; ratio is 64 + P |
| pulse_o | output | 1 | One-cycle pulse per output period |

## Verification
The chain's final state exists for one cycle, and the registered output pulse follows one rising edge later. A pulse is therefore due on the N-th edge after reset release and every N edges after that. The bench keeps a behavioural cycle counter that is updated on rising edges. It compares this counter with the output on every falling edge, one half period after the edge that produced the output. Periods are measured as the distance between falling-edge samples of the pulse. A new program word is driven just after a pulse has been seen, so it is judged only against the period that follows the next pulse.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
    // number of dual-modulus stages in the chain
    localparam int unsigned NUM_STAGES = 6;
    // phase width of one stage: phases 0, 1 and the swallow phase 2
    localparam int unsigned PH_W = 2;

    typedef struct packed {
        logic [PH_W-1:0] ph;
    } stage_state_t;

    typedef struct packed {
        logic pulse;
    } out_state_t;
endpackage

// File: rtl/dmc_stage.sv
module dmc_stage
    import dmc_pkg::*;
(
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic            tick_i,   // advance this stage in this cycle
    input  logic            mod_i,    // modulus-in from the slower neighbour
    input  logic            bit_i,    // program bit of this stage
    output logic            tick_o,   // carry to the slower neighbour
    output logic            mod_o,    // modulus-out to the faster neighbour
    output logic [PH_W-1:0] ph_o      // current phase
);
    localparam logic [PH_W-1:0] PH_ZERO = '0;
    localparam logic [PH_W-1:0] PH_ONE  = PH_W'(1);
    localparam logic [PH_W-1:0] PH_SWAL = PH_W'(2);

    stage_state_t st_d, st_q;
    logic         at_last;

    always_comb begin
        st_d = st_q;
        // the final phase is 1 unless a swallow is due, then phase 2
        at_last = (st_q.ph == PH_SWAL) ||
                  ((st_q.ph == PH_ONE) && !(bit_i && mod_i));
        mod_o  = mod_i && at_last;
        tick_o = tick_i && at_last;
        if (tick_i) begin
            if (at_last) st_d.ph = PH_ZERO;
            else         st_d.ph = st_q.ph + PH_ONE;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end

    assign ph_o = st_q.ph;

    // the phase never leaves the range 0..2
    p_phase_legal_r1: assert property (@(posedge clk_i) disable iff (rst_i)
        st_q.ph != 2'd3);

    // the swallow phase is only reached with the program bit set
    p_swallow_bit_r1: assert property (@(posedge clk_i) disable iff (rst_i)
        (st_q.ph == PH_SWAL) |-> bit_i);

    // leaving the swallow phase always returns to zero
    p_swallow_exit_r1: assert property (@(posedge clk_i) disable iff (rst_i)
        (st_q.ph == PH_SWAL && tick_i) |=> (st_q.ph == PH_ZERO));
endmodule

// File: rtl/dmc_prog_reg.sv
module dmc_prog_reg #(
    parameter int unsigned W = 6
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         load_i,   // start of a new output period
    input  logic [W-1:0] prog_i,
    output logic [W-1:0] prog_o
);
    logic [W-1:0] prog_d, prog_q;

    always_comb begin
        prog_d = prog_q;
        if (load_i) prog_d = prog_i;
    end

    // the word is also captured during reset for the first period
    always_ff @(posedge clk_i) begin
        if (rst_i) prog_q <= prog_i;
        else       prog_q <= prog_d;
    end

    assign prog_o = prog_q;
endmodule

// File: rtl/dual_mod_chain_div.sv
module dual_mod_chain_div
    import dmc_pkg::*;
(
    input  logic                  clk_i,
    input  logic                  rst_i,
    input  logic [NUM_STAGES-1:0] ratio_i,
    output logic                  pulse_o
);
    localparam int unsigned NS = NUM_STAGES;

    logic [NS-1:0]   prog_q;
    logic [NS:0]     tick_c;   // tick_c[k] advances stage k
    logic [NS:0]     mod_c;    // mod_c[k+1] is modulus-in of stage k
    logic [NS-1:0]   mod_out;
    logic [PH_W-1:0] ph [NS];
    logic            wrap;
    out_state_t      o_d, o_q;

    assign tick_c[0]  = 1'b1;
    assign mod_c[NS]  = 1'b1;   // slowest stage sees its modulus-in held high

    genvar k;
    generate
        for (k = 0; k < NS; k++) begin : g_stage
            dmc_stage u_stage (
                .clk_i  (clk_i),
                .rst_i  (rst_i),
                .tick_i (tick_c[k]),
                .mod_i  (mod_c[k+1]),
                .bit_i  (prog_q[k]),
                .tick_o (tick_c[k+1]),
                .mod_o  (mod_out[k]),
                .ph_o   (ph[k])
            );
            assign mod_c[k] = mod_out[k];
        end
    endgenerate

    // the fastest stage's modulus-out marks the last cycle of a period
    assign wrap = mod_c[0];

    dmc_prog_reg #(.W(NS)) u_prog (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .load_i (wrap),
        .prog_i (ratio_i),
        .prog_o (prog_q)
    );

    always_comb begin
        o_d = o_q;
        o_d.pulse = wrap;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) o_q <= '0;
        else       o_q <= o_d;
    end

    assign pulse_o = o_q.pulse;

    logic all_zero;
    always_comb begin
        all_zero = 1'b1;
        for (int i = 0; i < NS; i++)
            if (ph[i] != '0) all_zero = 1'b0;
    end

    // the ratio is at least 64, so a pulse is never followed by another
    p_pulse_single_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        pulse_o |=> !pulse_o);

    // the chain is back in its start phase while the pulse is shown
    p_start_phase_r1: assert property (@(posedge clk_i) disable iff (rst_i)
        pulse_o |-> all_zero);

    // the captured program word changes only across a period boundary
    p_prog_hold_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        !wrap |=> $stable(prog_q));

    // reset forces the output low
    p_reset_low_r5: assert property (@(posedge clk_i)
        rst_i |=> !pulse_o);
endmodule

// File: tb/dual_mod_chain_div_test.sv
module dual_mod_chain_div_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] ratio = 6'd5;
    logic       pulse;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 1'b0;

    dual_mod_chain_div uut (
        .clk_i   (clk),
        .rst_i   (rst),
        .ratio_i (ratio),
        .pulse_o (pulse)
    );

    always #10 clk = ~clk;   // 50 MHz

    // behavioural reference: a cycle counter and the current period length
    int  m_cnt = 0;
    int  m_len = 0;
    bit  m_exp = 1'b0;
    bit  m_valid = 1'b0;
    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0;
            m_len = 64 + int'(ratio);
            m_exp = 1'b0;
            m_valid = 1'b1;
        end else if (m_cnt == m_len - 1) begin
            m_cnt = 0;
            m_len = 64 + int'(ratio);
            m_exp = 1'b1;
        end else begin
            m_cnt = m_cnt + 1;
            m_exp = 1'b0;
        end
    end

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // per-cycle comparison against the reference (R3 and R4 timing)
    always @(negedge clk) begin
        cyc++;
        if (m_valid && !done) begin
            checks++;
            if (pulse !== m_exp) begin
                failures++;
                $display("FAIL R3 cycle %0d pulse=%b expected=%b", cyc, pulse, m_exp);
            end
        end
        if (cyc > 150000) begin
            failures++;
            $display("FAIL watchdog: run exceeded cycle limit actual=%0d expected<=150000", cyc);
            summary();
        end
    end

    task automatic check_int(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // counts falling edges until the pulse is seen high
    task automatic cycles_to_pulse(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (pulse !== 1'b1);
    endtask

    initial begin
        int n;
        // reset phase, R5
        repeat (4) @(negedge clk);
        check_int("R5 output low in reset", int'(pulse), 0);
        rst = 1'b0;
        cycles_to_pulse(n);
        check_int("R5 first period after reset", n, 69);

        // sweep every program word, R1 and R2
        for (int p = 0; p < 64; p++) begin
            ratio = 6'(p);             // applies from the period after the next pulse
            cycles_to_pulse(n);
            cycles_to_pulse(n);
            if (p == 0)       check_int("R2 minimum ratio", n, 64);
            else if (p == 63) check_int("R2 maximum ratio", n, 127);
            else              check_int("R1 period for program word", n, 64 + p);
        end

        // mid-period change, R4
        ratio = 6'd10;
        cycles_to_pulse(n);
        repeat (20) @(negedge clk);
        ratio = 6'd40;
        cycles_to_pulse(n);
        check_int("R4 period in progress unchanged", n + 20, 74);
        ratio = 6'd17;                 // driven after the pulse edge: not used next
        cycles_to_pulse(n);
        check_int("R4 new word from next period", n, 104);
        cycles_to_pulse(n);
        check_int("R4 later word after following pulse", n, 81);

        // reset in mid-period, R6
        ratio = 6'd33;
        repeat (30) @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check_int("R6 output low during mid-run reset", int'(pulse), 0);
        rst = 1'b0;
        cycles_to_pulse(n);
        check_int("R6 first period after mid-run reset", n, 97);
        cycles_to_pulse(n);
        check_int("R6 steady period after restart", n, 97);

        done = 1'b1;
        summary();
    end
endmodule